// File: doc/BRIEF.md
# Stalling Instruction Fetch Unit

This block is the fetch stage of a three-stage, single-issue, in-order pipeline. It drives a read-only WISHBONE classic instruction bus: a 30-bit word address and a strobe go out, and a 32-bit instruction word and an acknowledge come back. It holds the program counter and issues one fetch per instruction. While a fetch is outstanding it raises a stall that freezes every pipeline stage.

Each acknowledged fetch is handed to decode as a one-cycle `ins_valid_o` pulse. The pulse carries the word, its byte address and an interrupt-entry flag. There is no ready input: the stall output is the only back-pressure, and the fetch stage is the one that creates it. Each acknowledge yields exactly one delivery in the following cycle. Downstream stages must consume it or be frozen by `stall_o`.

Redirects come from two places. The execute stage signals a taken branch, and it keeps that signal stable while the pipeline is stalled. The fetch that is acknowledged while the branch is signalled is the instruction after the branch. If a delay slot is requested, that instruction is delivered as fetched. If not, it is replaced by a no-op. In both cases the next fetch goes to the target. A rising edge on the interrupt pin arms a pending flag. That flag redirects the next acknowledged fetch to a fixed vector. A branch at the same edge wins, so an interrupt never separates a branch from its delay slot.

Top module: `ifetch_stall_unit`

## Requirements
- R1: While `rst_n` is low, `ibus_stb_o` and `ins_valid_o` are low. The first fetch after reset is at word address 0.
- R2: Once the strobe is high without an acknowledge, the strobe stays high and the address stays unchanged in the next cycle.
- R3: `stall_o` is high exactly when `ibus_stb_o` is high and `ibus_ack_i` is low.
- R4: An acknowledged fetch with no branch and no interrupt taken moves the address to the next word (+1 word, i.e. +4 bytes) in the following cycle. The strobe stays high.
- R5: One cycle after an acknowledge, `ins_valid_o` is high for one cycle. It carries the acknowledged word and its byte address (word address shifted left by 2). In all other cycles `ins_valid_o` is low.
- R6: An acknowledge while `br_take_i` and `br_delay_i` are high delivers the fetched word unchanged. The next fetch address is `br_target_i[31:2]`.
- R7: An acknowledge while `br_take_i` is high and `br_delay_i` is low delivers `NOP_WORD` (default 32'h8000_0000) instead of the bus word. The next fetch address is `br_target_i[31:2]`.
- R8: A rising edge of `irq_i` sets a pending flag. The first later acknowledge without a branch takes the interrupt: the next fetch address is `VEC_ADDR[31:2]` (default byte 0x40), `ins_irq_o` is high with that delivery, and the pending flag clears.
- R9: A held-high or falling `irq_i` creates no new pending interrupt; only a low-to-high change does.
- R10: When an interrupt is pending at an acknowledge that carries a branch, the branch redirect is taken. The interrupt stays pending for the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ibus_adr_o | output | 30 | Instruction bus word address |
| ibus_stb_o | output | 1 | Instruction bus strobe |
| ibus_dat_i | input | 32 | Instruction bus read word |
| ibus_ack_i | input | 1 | Instruction bus acknowledge |
| stall_o | output | 1 | Pipeline freeze while a fetch is outstanding |
| br_take_i | input | 1 | Taken branch from execute |
| br_delay_i | input | 1 | Branch keeps its delay-slot instruction |
| br_target_i | input | 32 | Branch target byte address |
| irq_i | input | 1 | Interrupt, rising-edge sensitive |
| ins_valid_o | output | 1 | Instruction delivered this cycle |
| ins_word_o | output | 32 | Delivered instruction word |
| ins_pc_o | output | 32 | Byte address of delivered instruction |
| ins_irq_o | output | 1 | Delivery is the last before interrupt entry |

## Verification
The assertions assume that the slave raises an acknowledge only while the strobe is high. They also assume that the branch inputs are meaningful only in a cycle with an acknowledge. The bench slave acts on these rules: it asserts `ibus_ack_i` only after it has seen the strobe, and it drives `br_take_i` only in cycles where it also acknowledges. The interrupt pin is held low through reset. It toggles freely afterwards, so held, falling and rising levels all occur, and some of them coincide with branches.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned WA_W = XLEN - 2;
  typedef logic [WA_W-1:0] waddr_t;
  typedef logic [XLEN-1:0] word_t;
endpackage

// File: rtl/ifetch_irq_edge.sv
module ifetch_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic fire_i,
  input  logic br_take_i,
  output logic take_o
);
  logic irq_q;
  logic pend_q;
  logic rise;

  assign rise   = irq_i & ~irq_q;
  assign take_o = fire_i & pend_q & ~br_take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= (pend_q & ~take_o) | rise;
    end
  end

  // R10: a branch at the acknowledge keeps the interrupt pending
  a_r10_defer: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && fire_i && br_take_i) |=> pend_q);
endmodule

// File: rtl/ifetch_next_pc.sv
module ifetch_next_pc
  import ifetch_pkg::*;
#(
  parameter word_t VEC_ADDR = 32'h0000_0040
) (
  input  waddr_t pc_i,
  input  logic   br_take_i,
  input  word_t  br_target_i,
  input  logic   irq_take_i,
  output waddr_t next_o
);
  localparam waddr_t VEC_W = VEC_ADDR[XLEN-1:2];

  always_comb begin
    if (br_take_i)       next_o = br_target_i[XLEN-1:2];
    else if (irq_take_i) next_o = VEC_W;
    else                 next_o = pc_i + waddr_t'(1);
  end
endmodule

// File: rtl/ifetch_stall_unit.sv
module ifetch_stall_unit
  import ifetch_pkg::*;
#(
  parameter word_t VEC_ADDR = 32'h0000_0040,
  parameter word_t NOP_WORD = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [29:0] ibus_adr_o,
  output logic        ibus_stb_o,
  input  logic [31:0] ibus_dat_i,
  input  logic        ibus_ack_i,
  output logic        stall_o,
  input  logic        br_take_i,
  input  logic        br_delay_i,
  input  logic [31:0] br_target_i,
  input  logic        irq_i,
  output logic        ins_valid_o,
  output logic [31:0] ins_word_o,
  output logic [31:0] ins_pc_o,
  output logic        ins_irq_o
);
  localparam waddr_t VEC_W = VEC_ADDR[XLEN-1:2];

  logic   stb_q;
  waddr_t pc_q;
  waddr_t pc_next;
  waddr_t ins_pc_q;
  logic   fire;
  logic   irq_take;
  logic   kill;

  assign fire       = stb_q & ibus_ack_i;
  assign kill       = br_take_i & ~br_delay_i;
  assign stall_o    = stb_q & ~ibus_ack_i;
  assign ibus_stb_o = stb_q;
  assign ibus_adr_o = pc_q;
  assign ins_pc_o   = {ins_pc_q, 2'b00};

  ifetch_irq_edge u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_i     (irq_i),
    .fire_i    (fire),
    .br_take_i (br_take_i),
    .take_o    (irq_take)
  );

  ifetch_next_pc #(.VEC_ADDR(VEC_ADDR)) u_npc (
    .pc_i        (pc_q),
    .br_take_i   (br_take_i),
    .br_target_i (br_target_i),
    .irq_take_i  (irq_take),
    .next_o      (pc_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q       <= 1'b0;
      pc_q        <= '0;
      ins_valid_o <= 1'b0;
      ins_word_o  <= '0;
      ins_pc_q    <= '0;
      ins_irq_o   <= 1'b0;
    end else begin
      stb_q       <= 1'b1;
      ins_valid_o <= fire;
      if (fire) begin
        pc_q       <= pc_next;
        ins_word_o <= kill ? NOP_WORD : ibus_dat_i;
        ins_pc_q   <= pc_q;
        ins_irq_o  <= irq_take;
      end
    end
  end

  // R2: request held while waiting
  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_stb_o && !ibus_ack_i) |=> (ibus_stb_o && $stable(ibus_adr_o)));
  // R4: sequential step by one word
  a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_stb_o && ibus_ack_i && !br_take_i && !irq_take)
      |=> (ibus_adr_o == $past(ibus_adr_o) + 30'd1));
  // R5: delivery only after an acknowledge
  a_r5_deliver: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid_o |-> $past(ibus_stb_o && ibus_ack_i));
  // R6: branch redirect to target
  a_r6_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_stb_o && ibus_ack_i && br_take_i)
      |=> (ibus_adr_o == $past(br_target_i[31:2])));
  // R8: interrupt redirect to vector
  a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_stb_o && ibus_ack_i && irq_take) |=> (ibus_adr_o == VEC_W && ins_irq_o));
endmodule

// File: tb/ifetch_stall_unit_bench.sv
module ifetch_stall_unit_bench;
  localparam logic [31:0] VEC = 32'h0000_0040;
  localparam logic [31:0] NOP = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] adr;
  logic        stb, stall;
  logic [31:0] dat = '0;
  logic        ack = 1'b0;
  logic        br = 1'b0, brd = 1'b0;
  logic [31:0] btgt = '0;
  logic        irq = 1'b0;
  logic        iv, iirq;
  logic [31:0] iw, ipc;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ifetch_stall_unit u_ifetch_stall_unit (
    .clk(clk), .rst_n(rst_n), .ibus_adr_o(adr), .ibus_stb_o(stb),
    .ibus_dat_i(dat), .ibus_ack_i(ack), .stall_o(stall),
    .br_take_i(br), .br_delay_i(brd), .br_target_i(btgt), .irq_i(irq),
    .ins_valid_o(iv), .ins_word_o(iw), .ins_pc_o(ipc), .ins_irq_o(iirq));

  function automatic logic [31:0] memw(input logic [29:0] a);
    return {a[27:0], 4'h5} ^ 32'h3C96_A50F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [29:0] exp_adr;
    logic        pend, irq_prev, prev_fire, take;
    logic [31:0] exp_word, exp_pc;
    logic        exp_irq;
    int          wait_cnt;
    int          n_irq, n_kill, n_defer;
    void'($urandom(32'd1234));
    exp_adr = '0; pend = 0; irq_prev = 0; prev_fire = 0;
    exp_word = '0; exp_pc = '0; exp_irq = 0;
    n_irq = 0; n_kill = 0; n_defer = 0; wait_cnt = 0;
    repeat (3) @(negedge clk);
    chk(stb == 1'b0, "R1 stb in reset", {31'd0, stb}, 32'd0);
    chk(iv == 1'b0, "R1 valid in reset", {31'd0, iv}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stb == 1'b1, "R1 stb after reset", {31'd0, stb}, 32'd1);
    chk(adr == 30'd0, "R1 first address", {2'b0, adr}, 32'd0);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      // results of previous edge
      if (prev_fire) begin
        chk(iv == 1'b1, "R5 valid pulse", {31'd0, iv}, 32'd1);
        chk(iw == exp_word, "R5/R6/R7 word", iw, exp_word);
        chk(ipc == exp_pc, "R5 pc", ipc, exp_pc);
        chk(iirq == exp_irq, "R8/R9/R10 irq flag", {31'd0, iirq}, {31'd0, exp_irq});
        chk(adr == exp_adr, "R4/R6/R7/R8 next address", {2'b0, adr}, {2'b0, exp_adr});
      end else begin
        chk(iv == 1'b0, "R5 no pulse", {31'd0, iv}, 32'd0);
        chk(adr == exp_adr, "R2 address held", {2'b0, adr}, {2'b0, exp_adr});
      end
      chk(stb == 1'b1, "R2 strobe high", {31'd0, stb}, 32'd1);
      // drive inputs for this cycle
      if (wait_cnt == 0) wait_cnt = 1 + int'($urandom_range(0, 3));
      wait_cnt--;
      ack = (wait_cnt == 0);
      dat = ack ? memw(adr) : 32'hDEAD_BEEF;
      br  = ack && ($urandom_range(0, 5) == 0);
      brd = br && $urandom_range(0, 1) == 1;
      btgt = br ? $urandom : 32'h0;
      if ($urandom_range(0, 6) == 0) irq = ~irq;
      #1;
      chk(stall == (stb && !ack), "R3 stall", {31'd0, stall}, {31'd0, stb && !ack});
      // model of the edge
      take = ack && pend && !br;
      if (ack && pend && br) n_defer++;
      if (take) n_irq++;
      if (br && !brd) n_kill++;
      prev_fire = ack;
      if (ack) begin
        exp_word = (br && !brd) ? NOP : memw(adr);
        exp_pc   = {adr, 2'b00};
        exp_irq  = take;
        if (br) exp_adr = btgt[31:2];
        else if (take) exp_adr = VEC[31:2];
        else exp_adr = adr + 30'd1;
      end
      pend = (pend && !take) || (irq && !irq_prev);
      irq_prev = irq;
      @(negedge clk);
    end
    chk(n_irq > 0, "R8 interrupts taken", n_irq, 1);
    chk(n_kill > 0, "R7 killed slots seen", n_kill, 1);
    chk(n_defer > 0, "R10 deferrals seen", n_defer, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule